// File: doc/BRIEF.md
# Interleaved Banked Block-Read Memory

This block models main memory behind a cache and answers whole-block read requests over a narrow, one-word bus. A block holds `NUM_WORDS` words. Each word sits in its own bank, chosen by the low bits of its word address, so the four words of a block are spread across the four banks. A request is accepted while `ready_o` is high. The block then spends `ADDR_CYC` cycles taking the address and `ACCESS_CYC` cycles for a bank access. After that it returns the words one per cycle on `data_o`, with `valid_o` high for each word. `done_o` marks the last word.

The parameter `INTERLEAVED` picks one of two modes. When it is 1, all banks access at the same time and only the transfer runs one word after another, so a block takes 1 + 15 + 4 = 20 cycles. When it is 0, the memory acts as one word wide: each word waits for its own full access before it moves, so a block takes 1 + 4·15 + 4 = 65 cycles. A latency register shows the measured cycle count of the last finished request, so the two modes can be compared directly.

Top module: `blk_mem_responder`

## Requirements
- R1: While reset is held, and after it is released with no request, `ready_o` is 1 and `valid_o`, `done_o`, `data_o` and `lat_o` are 0.
- R2: Word i of block B comes from word address B·NUM_WORDS + i, which lives in bank i. Words are returned in ascending i order. The word at address a holds (a·0x0001_0003) XOR 0x5A5A_0000, truncated to 32 bits.
- R3: `done_o` is high only in the cycle that carries the last word of a block, and in no other cycle.
- R4: Take the clock edge that accepts a request as cycle 0. In interleaved mode the words appear in cycles 17, 18, 19 and 20. In serial mode (`INTERLEAVED`=0) they appear in cycles 17, 33, 49 and 65.
- R5: In the cycle after `done_o`, `lat_o` equals the request's total cycle count: 20 in interleaved mode and 65 in serial mode. It holds that value until the next `done_o`.
- R6: From acceptance until `done_o`, `ready_o` is 0. A `req_i` pulse or an address change in that window has no effect on the words returned.
- R7: `valid_o` is high for exactly one cycle per word, which gives exactly `NUM_WORDS` valid cycles per request.
- R8: `ready_o` is 1 in the cycle after `done_o`, so a new request can be accepted at the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Block read request, taken when `ready_o` is high |
| blk_addr_i | input | BLK_W | Block address of the request |
| ready_o | output | 1 | Idle; a request can be accepted |
| data_o | output | DATA_W | Returned word, zero when not valid |
| valid_o | output | 1 | `data_o` carries a word this cycle |
| done_o | output | 1 | Last word of the block is on `data_o` |
| lat_o | output | LAT_W | Cycle count of the most recently finished request |

## Verification
The checker assumes the requester drops or ignores `req_i` once it has been accepted, and that it only expects words after an accepted request. Its word counter and latency checks also assume a single requester that waits for `done_o` before it looks at `lat_o`. The bench stays within these limits by driving requests only while `ready_o` is high. During a transfer it adds random `req_i` pulses and random addresses that the block must refuse. It releases `req_i` in the `done_o` cycle, so none of this noise can start an unintended request.

// File: rtl/blk_mem_pkg.sv
package blk_mem_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACCESS,
    ST_XFER
  } seq_state_e;

  // Content model: every word address holds a fixed, address-derived value.
  function automatic logic [31:0] fill_word(input logic [31:0] waddr);
    return (waddr * 32'h0001_0003) ^ 32'h5A5A_0000;
  endfunction

endpackage

// File: rtl/blk_mem_bank.sv
module blk_mem_bank #(
  parameter int DATA_W    = 32,
  parameter int ROW_W     = 6,
  parameter int NUM_WORDS = 4,
  parameter int BANK_IDX  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ROW_W-1:0]  row_i,
  output logic [DATA_W-1:0] data_o
);
  import blk_mem_pkg::*;

  localparam int ROWS = 2 ** ROW_W;

  logic [DATA_W-1:0] mem_q [ROWS];

  // Contents are loaded at reset; the read path never modifies them.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) begin
        mem_q[r] <= DATA_W'(fill_word(32'(r * NUM_WORDS + BANK_IDX)));
      end
    end
  end

  assign data_o = mem_q[row_i];

endmodule

// File: rtl/blk_mem_seq.sv
module blk_mem_seq #(
  parameter int NUM_WORDS   = 4,
  parameter int ADDR_CYC    = 1,
  parameter int ACCESS_CYC  = 15,
  parameter int INTERLEAVED = 1,
  parameter int LAT_W       = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  output logic                         ready_o,
  output logic                         load_o,
  output logic [$clog2(NUM_WORDS)-1:0] word_o,
  output logic                         valid_o,
  output logic                         done_o,
  output logic [LAT_W-1:0]             lat_o
);
  import blk_mem_pkg::*;

  localparam int OFF_W  = $clog2(NUM_WORDS);
  localparam int PH_MAX = (ACCESS_CYC > ADDR_CYC) ? ACCESS_CYC : ADDR_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam logic [OFF_W-1:0] LAST_W   = OFF_W'(NUM_WORDS - 1);
  localparam logic [PH_W-1:0]  ADDR_END = PH_W'(ADDR_CYC - 1);
  localparam logic [PH_W-1:0]  ACC_END  = PH_W'(ACCESS_CYC - 1);

  seq_state_e       st_q;
  logic [PH_W-1:0]  ph_q;
  logic [OFF_W-1:0] w_q;
  logic [LAT_W-1:0] cnt_q;
  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ph_q  <= '0;
      w_q   <= '0;
      cnt_q <= '0;
      lat_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (req_i) begin
            st_q  <= ST_ADDR;
            ph_q  <= '0;
            w_q   <= '0;
            cnt_q <= LAT_W'(1);
          end
        end
        ST_ADDR: begin
          cnt_q <= cnt_q + 1'b1;
          if (ph_q == ADDR_END) begin
            st_q <= ST_ACCESS;
            ph_q <= '0;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        ST_ACCESS: begin
          cnt_q <= cnt_q + 1'b1;
          if (ph_q == ACC_END) begin
            st_q <= ST_XFER;
            ph_q <= '0;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        ST_XFER: begin
          if (w_q == LAST_W) begin
            st_q  <= ST_IDLE;
            lat_q <= cnt_q;
          end else begin
            w_q   <= w_q + 1'b1;
            cnt_q <= cnt_q + 1'b1;
            // Serial mode pays a full access for every word.
            if (INTERLEAVED == 0) st_q <= ST_ACCESS;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = (st_q == ST_IDLE);
  assign load_o  = (st_q == ST_ACCESS) && (ph_q == ACC_END);
  assign valid_o = (st_q == ST_XFER);
  assign done_o  = (st_q == ST_XFER) && (w_q == LAST_W);
  assign word_o  = w_q;
  assign lat_o   = lat_q;

endmodule

// File: rtl/blk_mem_responder.sv
module blk_mem_responder #(
  parameter int DATA_W      = 32,
  parameter int BLK_W       = 6,
  parameter int NUM_WORDS   = 4,
  parameter int ADDR_CYC    = 1,
  parameter int ACCESS_CYC  = 15,
  parameter int INTERLEAVED = 1,
  parameter int LAT_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [BLK_W-1:0]  blk_addr_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              done_o,
  output logic [LAT_W-1:0]  lat_o
);
  localparam int OFF_W = $clog2(NUM_WORDS);

  logic              load;
  logic [OFF_W-1:0]  word;
  logic [BLK_W-1:0]  blk_q;
  logic [DATA_W-1:0] bank_rd [NUM_WORDS];
  logic [DATA_W-1:0] buf_q   [NUM_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               blk_q <= '0;
    else if (req_i && ready_o) blk_q <= blk_addr_i;
  end

  blk_mem_seq #(
    .NUM_WORDS  (NUM_WORDS),
    .ADDR_CYC   (ADDR_CYC),
    .ACCESS_CYC (ACCESS_CYC),
    .INTERLEAVED(INTERLEAVED),
    .LAT_W      (LAT_W)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .ready_o(ready_o),
    .load_o (load),
    .word_o (word),
    .valid_o(valid_o),
    .done_o (done_o),
    .lat_o  (lat_o)
  );

  for (genvar b = 0; b < NUM_WORDS; b++) begin : g_bank
    blk_mem_bank #(
      .DATA_W   (DATA_W),
      .ROW_W    (BLK_W),
      .NUM_WORDS(NUM_WORDS),
      .BANK_IDX (b)
    ) u_bank (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .row_i (blk_q),
      .data_o(bank_rd[b])
    );

    // Interleaved: all banks land together. Serial: only the word in service.
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) buf_q[b] <= '0;
      else if (load && (INTERLEAVED != 0 || word == OFF_W'(b))) buf_q[b] <= bank_rd[b];
    end
  end

  assign data_o = valid_o ? buf_q[word] : '0;

endmodule

// File: rtl/blk_mem_responder_chk.sv
module blk_mem_responder_chk #(
  parameter int NUM_WORDS   = 4,
  parameter int ADDR_CYC    = 1,
  parameter int ACCESS_CYC  = 15,
  parameter int INTERLEAVED = 1,
  parameter int LAT_W       = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             ready_o,
  input logic             valid_o,
  input logic             done_o,
  input logic [LAT_W-1:0] lat_o
);
  localparam int EXP_LAT = (INTERLEAVED != 0)
                         ? ADDR_CYC + ACCESS_CYC + NUM_WORDS
                         : ADDR_CYC + NUM_WORDS * (ACCESS_CYC + 1);
  localparam int VC_W = $clog2(NUM_WORDS) + 1;

  logic [VC_W-1:0] vcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vcnt_q <= '0;
    else if (done_o)  vcnt_q <= '0;
    else if (valid_o) vcnt_q <= vcnt_q + 1'b1;
  end

  a_r3_done_on_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> valid_o);

  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!valid_o && !done_o));

  a_r6_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);

  a_r8_ready_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ready_o);

  a_r7_word_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (vcnt_q == VC_W'(NUM_WORDS - 1)));

  a_r5_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(done_o) |-> (lat_o == LAT_W'(EXP_LAT)));

  a_r5_lat_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(done_o) |-> $stable(lat_o));

  if (INTERLEAVED != 0) begin : g_burst
    a_r4_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !done_o) |=> valid_o);
  end else begin : g_gap
    a_r4_gap_after_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |=> !valid_o);
  end

endmodule

bind blk_mem_responder blk_mem_responder_chk #(
  .NUM_WORDS  (NUM_WORDS),
  .ADDR_CYC   (ADDR_CYC),
  .ACCESS_CYC (ACCESS_CYC),
  .INTERLEAVED(INTERLEAVED),
  .LAT_W      (LAT_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .ready_o(ready_o),
  .valid_o(valid_o),
  .done_o (done_o),
  .lat_o  (lat_o)
);

// File: tb/blk_mem_responder_bench.sv
`timescale 1ns/1ps
module blk_mem_responder_bench;
  localparam int DATA_W = 32;
  localparam int BLK_W  = 6;
  localparam int LAT_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_a = 1'b0, req_b = 1'b0;
  logic [BLK_W-1:0] addr = '0;

  logic              rdy_a, val_a, don_a, rdy_b, val_b, don_b;
  logic [DATA_W-1:0] dat_a, dat_b;
  logic [LAT_W-1:0]  lat_a, lat_b;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  blk_mem_responder #(.INTERLEAVED(1)) u_blk_mem_responder (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_a), .blk_addr_i(addr),
    .ready_o(rdy_a), .data_o(dat_a), .valid_o(val_a), .done_o(don_a), .lat_o(lat_a));

  blk_mem_responder #(.INTERLEAVED(0)) u_blk_mem_responder_ser (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_b), .blk_addr_i(addr),
    .ready_o(rdy_b), .data_o(dat_b), .valid_o(val_b), .done_o(don_b), .lat_o(lat_b));

  function automatic logic [31:0] exp_word(input int waddr);
    return (32'(waddr) * 32'h0001_0003) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called just after a negedge; leaves at the negedge following done.
  task automatic run_req(input bit ser, input int blk, input bit noise);
    int total;
    bit ok_t;
    bit ok_l;
    logic [LAT_W-1:0] lat0;
    total = ser ? 65 : 20;
    ok_t = 1'b1;
    ok_l = 1'b1;
    lat0 = ser ? lat_b : lat_a;
    chk(ser ? rdy_b : rdy_a, "R8 ready before request", 0, 1);
    addr = BLK_W'(blk);
    if (ser) req_b = 1'b1; else req_a = 1'b1;
    @(posedge clk);
    for (int n = 1; n <= total; n++) begin
      bit ev, v, d, r;
      int idx;
      logic [DATA_W-1:0] dv;
      logic [LAT_W-1:0] lv;
      @(negedge clk);
      if (noise && n < total) begin
        if (ser) req_b = $urandom_range(0, 1); else req_a = $urandom_range(0, 1);
        addr = BLK_W'($urandom);
      end else begin
        req_a = 1'b0;
        req_b = 1'b0;
      end
      v  = ser ? val_b : val_a;
      d  = ser ? don_b : don_a;
      r  = ser ? rdy_b : rdy_a;
      dv = ser ? dat_b : dat_a;
      lv = ser ? lat_b : lat_a;
      ev = ser ? (n >= 17 && ((n - 17) % 16 == 0)) : (n >= 17);
      idx = ser ? (n - 17) / 16 : n - 17;
      if (v != ev || d != (n == total) || r) ok_t = 1'b0;
      if (lv != lat0) ok_l = 1'b0;
      if (ev && v) chk(dv == exp_word(blk * 4 + idx),
                       noise ? "R2/R6 word under ignored requests" : "R2 word value",
                       dv, exp_word(blk * 4 + idx));
    end
    chk(ok_t, "R3/R4/R7 valid, done and ready timing", ok_t, 1);
    chk(ok_l, "R5 latency held during request", ok_l, 1);
    @(negedge clk);
    chk((ser ? lat_b : lat_a) == LAT_W'(total), "R5 measured latency",
        ser ? lat_b : lat_a, total);
    chk(ser ? rdy_b : rdy_a, "R8 ready after done", 0, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E_3D4C));
    repeat (3) @(negedge clk);
    chk(rdy_a && !val_a && !don_a && dat_a == 0 && lat_a == 0, "R1 reset state interleaved", lat_a, 0);
    chk(rdy_b && !val_b && !don_b && dat_b == 0 && lat_b == 0, "R1 reset state serial", lat_b, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(rdy_a && !val_a && lat_a == 0, "R1 idle after reset", lat_a, 0);

    // Directed corners: lowest and highest block, back-to-back, ignored requests.
    run_req(1'b0, 0, 1'b0);
    run_req(1'b0, (1 << BLK_W) - 1, 1'b0);
    run_req(1'b0, 21, 1'b1);
    run_req(1'b1, 0, 1'b0);
    run_req(1'b1, (1 << BLK_W) - 1, 1'b1);

    for (int i = 0; i < 24; i++) begin
      run_req(i[0], int'($urandom_range(0, (1 << BLK_W) - 1)), bit'($urandom_range(0, 1)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule